// File: doc/BRIEF.md
# Ternary Bitwise Lookup Logic Unit

This unit evaluates any Boolean function of three inputs, chosen by an 8-entry truth table, across 64-bit operands. In the bitwise forms every bit position builds a 3-bit index from the old destination bit (most significant), the first source bit and the second source bit. It then returns the table entry selected by that index. The table comes either from an immediate that arrives as two fields, or from the low byte of a fourth register operand.

Two further forms share the same lookup. The byte-lane form takes its three index bits from three bytes of the first source. It produces one 8-bit result and writes that byte into any subset of the four low byte lanes of the destination, chosen by a mask. The whole-operand form reduces each operand to zero/nonzero and returns a single table bit, zero-extended.

An operation is accepted when `issue` is high at a rising clock edge. Its result is registered at that edge, and `result_valid` is high during the following cycle. A small two-state controller (`ST_IDLE`, `ST_HOLD`) tracks validity. ST_IDLE moves to ST_HOLD on issue. ST_HOLD stays in ST_HOLD on a further issue and returns to ST_IDLE when no issue arrives.

Top module: `ternlut_unit`

## Requirements
- R1: While `rst_n` is low and after its release, until the first issue, `result` is zero and `result_valid` is low.
- R2: When `issue` is high at a rising edge, `result` takes that operation's value at that edge and `result_valid` is high for the next cycle; without issue, `result_valid` is low in the next cycle.
- R3: With `mode` = 2'b00 (bitwise, immediate table), result bit i equals table bit number {rt_in[i], ra_in[i], rb_in[i]}, where rt_in gives index bit 2 and rb_in gives index bit 0.
- R4: The immediate table is {tbl_hi, tbl_lo}: tbl_hi[2:0] supplies table bits 7..5 and tbl_lo[4:0] supplies table bits 4..0.
- R5: With `mode` = 2'b01 (bitwise, register table), the table is rc_in[7:0]; rc_in[63:8] has no effect on the result.
- R6: With `mode` = 2'b10 (byte lane), an 8-bit value is formed whose bit k is immediate table bit {ra_in[k], ra_in[8+k], ra_in[16+k]}, so byte 0 of ra_in gives index bit 2 and byte 2 gives index bit 0.
- R7: In byte-lane mode, for each set bit j of `lane_mask` the 8-bit value is written to result bits 8j+7..8j; unmasked lanes and bits 63..32 equal rt_in.
- R8: With `mode` = 2'b11 (whole operand), the index is {rt_in!=0, ra_in!=0, rb_in!=0} into the immediate table, and result bits 63..1 are zero.
- R9: When `issue` is low at an edge, `result` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Accept an operation at this edge |
| mode | input | 2 | 00 bitwise/imm, 01 bitwise/reg, 10 byte lane, 11 whole operand |
| rt_in | input | 64 | Old destination value, index bit 2 |
| ra_in | input | 64 | First source, index bit 1 (lane source in byte-lane mode) |
| rb_in | input | 64 | Second source, index bit 0 |
| rc_in | input | 64 | Register table source, low byte used |
| tbl_lo | input | 5 | Immediate table bits 4..0 |
| tbl_hi | input | 3 | Immediate table bits 7..5 |
| lane_mask | input | 4 | Byte lanes written in byte-lane mode |
| result | output | 64 | Registered result |
| result_valid | output | 1 | High in the cycle after an accepted operation |

## Verification
Tables 0xF0, 0xCC and 0xAA must reproduce rt, ra and rb exactly. A design that swapped index bit order would return the wrong operand for them. Register mode is driven with noisy upper bits in rc_in and compared against a run with those bits changed, which catches a design that reads the wrong byte. Lane mask 0 and sparse masks catch a design that clobbers unmasked lanes or the upper half. Whole-operand cases with single nonzero operands catch a design that tests bits instead of whole values or leaves junk above bit 0. Seeded random operations across all modes, plus an idle cycle with changed inputs, cover the remaining paths.

// File: rtl/ternlut_pkg.sv
package ternlut_pkg;

    localparam int TBL_W = 8;

    typedef enum logic [1:0] {
        MD_BIT_IMM = 2'b00,
        MD_BIT_REG = 2'b01,
        MD_LANE    = 2'b10,
        MD_WHOLE   = 2'b11
    } lut_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } lut_state_e;

    function automatic logic lut3(input logic [TBL_W-1:0] tbl,
                                  input logic hi, input logic mid, input logic lo);
        return tbl[{hi, mid, lo}];
    endfunction

endpackage

// File: rtl/ternlut_bitwise.sv
module ternlut_bitwise
    import ternlut_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] rt,
    input  logic [DATA_W-1:0] ra,
    input  logic [DATA_W-1:0] rb,
    input  logic [TBL_W-1:0]  tbl,
    output logic [DATA_W-1:0] res
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign res[i] = lut3(tbl, rt[i], ra[i], rb[i]);
    end
endmodule

// File: rtl/ternlut_lane.sv
module ternlut_lane
    import ternlut_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [DATA_W-1:0]   rt,
    input  logic [3*LANE_W-1:0] ra_lo,
    input  logic [TBL_W-1:0]    tbl,
    input  logic [LANES-1:0]    mask,
    output logic [DATA_W-1:0]   res
);
    localparam int COVER_W = LANE_W * LANES;

    logic [LANE_W-1:0] lane_val;

    for (genvar k = 0; k < LANE_W; k++) begin : g_lbit
        assign lane_val[k] = lut3(tbl, ra_lo[k], ra_lo[LANE_W + k], ra_lo[2*LANE_W + k]);
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign res[j*LANE_W +: LANE_W] = mask[j] ? lane_val : rt[j*LANE_W +: LANE_W];
    end

    if (COVER_W < DATA_W) begin : g_upper
        assign res[DATA_W-1:COVER_W] = rt[DATA_W-1:COVER_W];
    end
endmodule

// File: rtl/ternlut_whole.sv
module ternlut_whole
    import ternlut_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] rt,
    input  logic [DATA_W-1:0] ra,
    input  logic [DATA_W-1:0] rb,
    input  logic [TBL_W-1:0]  tbl,
    output logic [DATA_W-1:0] res
);
    assign res = {{(DATA_W-1){1'b0}}, lut3(tbl, |rt, |ra, |rb)};
endmodule

// File: rtl/ternlut_unit.sv
module ternlut_unit
    import ternlut_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] rt_in,
    input  logic [DATA_W-1:0] ra_in,
    input  logic [DATA_W-1:0] rb_in,
    input  logic [DATA_W-1:0] rc_in,
    input  logic [4:0]        tbl_lo,
    input  logic [2:0]        tbl_hi,
    input  logic [LANES-1:0]  lane_mask,
    output logic [DATA_W-1:0] result,
    output logic              result_valid
);
    lut_state_e state_q, state_d;

    logic [TBL_W-1:0]        imm_tbl;
    logic [TBL_W-1:0]        bit_tbl;
    logic [DATA_W-1:TBL_W]   rc_unused;
    logic [DATA_W-1:0]       bit_res, lane_res, whole_res, next_res;
    lut_mode_e               mode_e;

    assign mode_e    = lut_mode_e'(mode);
    assign imm_tbl   = {tbl_hi, tbl_lo};
    assign rc_unused = rc_in[DATA_W-1:TBL_W];
    assign bit_tbl   = (mode_e == MD_BIT_REG) ? rc_in[TBL_W-1:0] : imm_tbl;

    ternlut_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .rt(rt_in), .ra(ra_in), .rb(rb_in), .tbl(bit_tbl), .res(bit_res)
    );

    ternlut_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_lane (
        .rt(rt_in), .ra_lo(ra_in[3*LANE_W-1:0]), .tbl(imm_tbl),
        .mask(lane_mask), .res(lane_res)
    );

    ternlut_whole #(.DATA_W(DATA_W)) u_whole (
        .rt(rt_in), .ra(ra_in), .rb(rb_in), .tbl(imm_tbl), .res(whole_res)
    );

    always_comb begin
        unique case (mode_e)
            MD_BIT_IMM, MD_BIT_REG: next_res = bit_res;
            MD_LANE:                next_res = lane_res;
            MD_WHOLE:               next_res = whole_res;
            default:                next_res = bit_res;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (issue)  state_d = ST_HOLD;
            ST_HOLD: if (!issue) state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     result <= '0;
        else if (issue) result <= next_res;
    end

    assign result_valid = (state_q == ST_HOLD);
endmodule

// File: rtl/ternlut_chk.sv
module ternlut_chk #(
    parameter int DATA_W = 64,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] rt_in,
    input logic [LANES-1:0]  lane_mask,
    input logic [DATA_W-1:0] result,
    input logic              result_valid
);
    p_valid_after_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> result_valid);

    p_no_valid_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !result_valid);

    p_hold_without_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(result));

    p_whole_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && mode == 2'b11) |=> (result[DATA_W-1:1] == '0));

    p_lane_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && mode == 2'b10) |=> (result[DATA_W-1:32] == $past(rt_in[DATA_W-1:32])));

    p_lane_nomask_keeps_rt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && mode == 2'b10 && lane_mask == '0) |=> (result == $past(rt_in)));
endmodule

bind ternlut_unit ternlut_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue(issue), .mode(mode), .rt_in(rt_in),
    .lane_mask(lane_mask), .result(result), .result_valid(result_valid)
);

// File: tb/ternlut_unit_bench.sv
module ternlut_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [63:0] rt_in = '0, ra_in = '0, rb_in = '0, rc_in = '0;
    logic [4:0]  tbl_lo = '0;
    logic [2:0]  tbl_hi = '0;
    logic [3:0]  lane_mask = '0;
    logic [63:0] result;
    logic        result_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ternlut_unit u_ternlut_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .mode(mode),
        .rt_in(rt_in), .ra_in(ra_in), .rb_in(rb_in), .rc_in(rc_in),
        .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .lane_mask(lane_mask),
        .result(result), .result_valid(result_valid)
    );

    function automatic logic [63:0] model(input logic [1:0] md, input logic [63:0] t,
        input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
        input logic [4:0] lo, input logic [2:0] hi, input logic [3:0] msk);
        logic [7:0]  tb;
        logic [7:0]  lv;
        logic [63:0] r;
        tb = (md == 2'b01) ? c[7:0] : {hi, lo};
        r  = '0;
        case (md)
            2'b00, 2'b01: for (int i = 0; i < 64; i++) r[i] = tb[{t[i], a[i], b[i]}];
            2'b10: begin
                for (int k = 0; k < 8; k++) lv[k] = tb[{a[k], a[8+k], a[16+k]}];
                r = t;
                for (int j = 0; j < 4; j++) if (msk[j]) r[8*j +: 8] = lv;
            end
            default: r[0] = tb[{t != 0, a != 0, b != 0}];
        endcase
        return r;
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [1:0] md, input logic [63:0] t,
        input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
        input logic [7:0] tb, input logic [3:0] msk);
        mode = md; rt_in = t; ra_in = a; rb_in = b; rc_in = c;
        tbl_hi = tb[7:5]; tbl_lo = tb[4:0]; lane_mask = msk; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check64(req, result, model(md, t, a, b, c, tb[4:0], tb[7:5], msk));
        check64({req, " valid"}, {63'b0, result_valid}, 64'd1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [63:0] r1;
        void'($urandom(32'h5EED_0101));
        repeat (3) @(negedge clk);
        // R1: reset state
        check64("R1 reset result", result, 64'd0);
        check64("R1 reset valid", {63'b0, result_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R1 after release", result, 64'd0);

        // R3: identity tables expose index bit order
        run_op("R3 tbl F0 gives rt", 2'b00, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 64'h5555_AAAA_3333_CCCC, 0, 8'hF0, 0);
        run_op("R3 tbl CC gives ra", 2'b00, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 64'h5555_AAAA_3333_CCCC, 0, 8'hCC, 0);
        run_op("R3 tbl AA gives rb", 2'b00, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 64'h5555_AAAA_3333_CCCC, 0, 8'hAA, 0);
        run_op("R3 tbl 96 xor3", 2'b00, 64'hDEAD_BEEF_0000_FFFF, 64'h1234_5678_9ABC_DEF0, 64'hF0F0_0F0F_AAAA_5555, 0, 8'h96, 0);
        // R4: field split
        run_op("R4 hi field only (and3)", 2'b00, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00, 0, 8'h80, 0);
        run_op("R4 lo field only", 2'b00, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00, 0, 8'h01, 0);
        // R5: register table, upper rc ignored
        run_op("R5 reg table E8", 2'b01, 64'hA5A5_5A5A_0F0F_F0F0, 64'h3C3C_C3C3_FF00_00FF, 64'h6666_9999_1111_EEEE, 64'hFFFF_FFFF_FFFF_FFE8, 8'h00, 0);
        r1 = result;
        run_op("R5 reg table upper changed", 2'b01, 64'hA5A5_5A5A_0F0F_F0F0, 64'h3C3C_C3C3_FF00_00FF, 64'h6666_9999_1111_EEEE, 64'h1234_0000_0000_00E8, 8'h00, 0);
        check64("R5 upper rc no effect", result, r1);
        // R6 / R7: byte lane
        run_op("R6 lane all mask", 2'b10, 64'h1111_2222_3333_4444, 64'h9999_0000_00F0_CCAA, 0, 0, 8'hE8, 4'hF);
        run_op("R7 lane mask zero", 2'b10, 64'h1111_2222_3333_4444, 64'h9999_0000_00F0_CCAA, 0, 0, 8'hE8, 4'h0);
        run_op("R7 lane mask 1010", 2'b10, 64'hCAFE_F00D_1234_5678, 64'h0000_0000_0055_0F33, 0, 0, 8'h96, 4'hA);
        // R8: whole operand
        run_op("R8 all zero idx0", 2'b11, 0, 0, 0, 0, 8'h01, 0);
        run_op("R8 rt only idx4", 2'b11, 64'h8000_0000_0000_0000, 0, 0, 0, 8'h10, 0);
        run_op("R8 rb only not idx4", 2'b11, 0, 0, 64'h1, 0, 8'h10, 0);
        run_op("R8 all nonzero idx7", 2'b11, 64'h2, 64'h4, 64'h8, 0, 8'h80, 0);

        // R9 / R2: idle cycle with new inputs
        held = result;
        rt_in = '1; ra_in = '1; rb_in = '1; tbl_hi = 3'b111; tbl_lo = 5'h1F; mode = 2'b00;
        @(negedge clk);
        check64("R9 hold without issue", result, held);
        check64("R2 valid low when idle", {63'b0, result_valid}, 64'd0);

        // R2 and all modes: seeded random back-to-back operations
        for (int n = 0; n < 300; n++) begin
            run_op("R2 random op", 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom), 4'($urandom));
            if ((n % 7) == 0) begin
                held = result;
                ra_in = {$urandom, $urandom};
                @(negedge clk);
                check64("R9 random hold", result, held);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule